// File: doc/BRIEF.md
# Watchdog Supervisor with Dual-Boot Select

This block supervises a system controller that pairs a processor with programmable fabric. It stretches a power-on reset, then runs a watchdog that must be fed by an alive event. A fresh rising edge from the software heartbeat and a fresh rising edge from the fabric heartbeat together make one alive event. While the self-test block raises its major-risk flag, no alive event is formed. The watchdog then expires and forces a reconfiguration reboot through the same reset output.

A second output selects the boot device. It reads nominal when power comes up. A digital delay timer started by the power-on reset switches it to the redundant device. The delay is longer than the power-on reset and shorter than one watchdog period. So the first boot always loads from the nominal device. If that boot never feeds the watchdog, the next reset loads from the redundant device. The selection stays latched until power-good drops.

All timeouts are parameters counted in clock cycles. The defaults assume a 250 MHz clock with a 1.6 s watchdog period. The heartbeat and risk inputs may be asynchronous and pass through synchronizers of `SYNC_STAGES` flops; the figures below assume the default of two.

Top module: `watchdog_boot_supervisor`

## Requirements
- R1: While `pwr_good` is low, `sys_rst_n` is low and `boot_nominal` is high (1 = nominal device, 0 = redundant device).
- R2: After `pwr_good` rises, `sys_rst_n` first reads high after the (POR_CYCLES+2)-th rising clock edge: two synchronizer edges, then POR_CYCLES cycles of stretch.
- R3: At the release of the power-on reset, `boot_nominal` is still high, so the first boot uses the nominal device.
- R4: `boot_nominal` first reads low after the (BOOT_DELAY_CYCLES+2)-th rising edge after `pwr_good` rises. It stays low through every later watchdog reset until `pwr_good` drops.
- R5: With no alive event, `sys_rst_n` goes low exactly WDT_CYCLES cycles after it was released.
- R6: A watchdog reset holds `sys_rst_n` low for exactly RST_CYCLES cycles. The watchdog counter does not run meanwhile.
- R7: Both heartbeats rising at a period well below WDT_CYCLES keep `sys_rst_n` high for as long as they continue.
- R8: An alive event restarts the watchdog. If the completing heartbeat rise is presented before rising edge a, and no further alive event follows, `sys_rst_n` goes low at edge a+WDT_CYCLES+3.
- R9: Heartbeat inputs held high count as no alive event. Only a low-to-high transition counts.
- R10: Rising edges on only one of the two heartbeats never form an alive event.
- R11: While `risk_major` is high, no alive event is formed, even with both heartbeats toggling.
- R12: Heartbeat edges that arrive while `sys_rst_n` is low are discarded. They cannot pair with an edge seen after release.
- R13: A low level on `pwr_good` drives `sys_rst_n` low and `boot_nominal` high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| pwr_good | input | 1 | Power-good level; low acts as asynchronous power-on reset |
| sw_beat | input | 1 | Software heartbeat; rising edge counts |
| fab_beat | input | 1 | Fabric heartbeat; rising edge counts |
| risk_major | input | 1 | Self-test major-risk flag; high vetoes alive events |
| sys_rst_n | output | 1 | System reset, active low |
| boot_nominal | output | 1 | Boot device select: 1 nominal, 0 redundant |

## Verification
The watchdog is driven with several input patterns, and each one separates a different fault:
- No heartbeat at all gives the base timeout.
- Both heartbeats toggling periodically shows feeding works.
- A single completing edge at a known cycle pins the restart latency exactly.
- Inputs held high separate level detection from edge detection.
- Only one heartbeat toggling exposes a combiner that uses OR in place of AND.
- Both toggling under the risk flag exposes a missing veto.
- An edge that lands inside the reset pulse exposes pairing flags that are not cleared.

The boot selection is observed at the start of every reset and release interval. A power drop and a second power-up check that the latched redundant selection returns to nominal.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
  // positions of the asynchronous inputs inside the synchronizer vector
  localparam int HB_SW   = 0;
  localparam int HB_FAB  = 1;
  localparam int HB_RISK = 2;
  localparam int N_SYNC  = 3;

  // bits needed to hold the value n
  function automatic int cnt_bits(input int unsigned n);
    cnt_bits = (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wdsup_por_sync.sv
module wdsup_por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pwr_good,
  output logic por_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // assertion is asynchronous, release walks through the chain
  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign por_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdsup_in_sync.sv
module wdsup_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
      end else begin
        stg_q <= stg_d;
      end
    end

    assign d_out[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/wdsup_alive_comb.sv
module wdsup_alive_comb (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,      // system reset active: discard everything
  input  logic sw_s,
  input  logic fab_s,
  input  logic risk_s,
  output logic alive
);
  logic [1:0] prev_q, prev_d;
  logic [1:0] seen_q, seen_d;
  logic [1:0] rise;
  logic [1:0] avail;
  logic       fire;
  logic       alive_q;

  always_comb begin
    rise   = {fab_s, sw_s} & ~prev_q;
    avail  = seen_q | rise;
    fire   = (&avail) & ~risk_s & ~clr;
    prev_d = {fab_s, sw_s};
    if (clr || risk_s || fire) begin
      seen_d = '0;
    end else begin
      seen_d = avail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      seen_q  <= '0;
      alive_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      seen_q  <= seen_d;
      alive_q <= fire;
    end
  end

  assign alive = alive_q;

  // R11: risk flag vetoes the alive event
  a_r11_risk_vetoes_alive: assert property (@(posedge clk) disable iff (!rst_n)
    risk_s |=> !alive_q);

  // R12: nothing seen during system reset produces an alive event
  a_r12_no_alive_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !alive_q);
endmodule

// File: rtl/wdsup_wdt.sv
module wdsup_wdt
  import wdsup_pkg::*;
#(
  parameter int unsigned WDT_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,     // system reset active
  input  logic alive,
  output logic timeout
);
  localparam int CW = cnt_bits(WDT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          expire;

  always_comb begin
    cnt_en = 1'b1;
    expire = ~hold & ~alive & (cnt_q == LAST);
    if (hold || alive || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign timeout = expire;

  // R6: the watchdog cannot fire while the system is held in reset
  a_r6_quiet_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !timeout);
endmodule

// File: rtl/wdsup_rst_gen.sv
module wdsup_rst_gen
  import wdsup_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 50_000_000,
  parameter int unsigned RST_CYCLES = 35_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_active
);
  localparam int unsigned MAXV = (POR_CYCLES > RST_CYCLES) ? POR_CYCLES : RST_CYCLES;
  localparam int CW = cnt_bits(MAXV);
  localparam logic [CW-1:0] POR_LD   = CW'(POR_CYCLES);
  localparam logic [CW-1:0] PULSE_LD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          act_q, act_d;

  always_comb begin
    cnt_en = trig | (cnt_q != '0);
    if (trig) begin
      cnt_d = PULSE_LD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end else begin
      cnt_d = '0;
    end
    act_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= POR_LD;
      act_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign rst_active = act_q;
endmodule

// File: rtl/wdsup_boot_timer.sv
module wdsup_boot_timer
  import wdsup_pkg::*;
#(
  parameter int unsigned BOOT_DELAY_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic boot_nom
);
  localparam int CW = cnt_bits(BOOT_DELAY_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(BOOT_DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          boot_q, boot_d;
  logic          tmr_en;

  always_comb begin
    tmr_en = boot_q;      // timer freezes once the selection has flipped
    cnt_d  = cnt_q + CW'(1);
    boot_d = (cnt_q != LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      boot_q <= 1'b1;
    end else if (tmr_en) begin
      cnt_q  <= cnt_d;
      boot_q <= boot_d;
    end
  end

  assign boot_nom = boot_q;

  // R4: once redundant, stays redundant until power is removed
  a_r4_select_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);
endmodule

// File: rtl/watchdog_boot_supervisor.sv
module watchdog_boot_supervisor
  import wdsup_pkg::*;
#(
  parameter int          SYNC_STAGES       = 2,
  parameter int unsigned POR_CYCLES        = 50_000_000,
  parameter int unsigned WDT_CYCLES        = 400_000_000,
  parameter int unsigned RST_CYCLES        = 35_000,
  parameter int unsigned BOOT_DELAY_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic sw_beat,
  input  logic fab_beat,
  input  logic risk_major,
  output logic sys_rst_n,
  output logic boot_nominal
);
  logic              por_n;
  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] syn_in;
  logic              alive;
  logic              wd_timeout;
  logic              rst_active;

  assign raw_in[HB_SW]   = sw_beat;
  assign raw_in[HB_FAB]  = fab_beat;
  assign raw_in[HB_RISK] = risk_major;

  wdsup_por_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk      (clk),
    .pwr_good (pwr_good),
    .por_n    (por_n)
  );

  wdsup_in_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d_in  (raw_in),
    .d_out (syn_in)
  );

  wdsup_alive_comb u_alive (
    .clk    (clk),
    .rst_n  (por_n),
    .clr    (rst_active),
    .sw_s   (syn_in[HB_SW]),
    .fab_s  (syn_in[HB_FAB]),
    .risk_s (syn_in[HB_RISK]),
    .alive  (alive)
  );

  wdsup_wdt #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
    .clk     (clk),
    .rst_n   (por_n),
    .hold    (rst_active),
    .alive   (alive),
    .timeout (wd_timeout)
  );

  wdsup_rst_gen #(.POR_CYCLES(POR_CYCLES), .RST_CYCLES(RST_CYCLES)) u_rst_gen (
    .clk        (clk),
    .rst_n      (por_n),
    .trig       (wd_timeout),
    .rst_active (rst_active)
  );

  wdsup_boot_timer #(.BOOT_DELAY_CYCLES(BOOT_DELAY_CYCLES)) u_boot (
    .clk      (clk),
    .rst_n    (por_n),
    .boot_nom (boot_nominal)
  );

  assign sys_rst_n = ~rst_active;

  // R5: an expiring watchdog drives the system reset on the next cycle
  a_r5_expiry_drives_reset: assert property (@(posedge clk) disable iff (!por_n)
    wd_timeout |=> !sys_rst_n);
endmodule

// File: tb/tb_watchdog_boot_supervisor.sv
module tb_watchdog_boot_supervisor;
  localparam int unsigned POR  = 20;
  localparam int unsigned WDT  = 200;
  localparam int unsigned RSTP = 10;
  localparam int unsigned BOOT = 60;

  // 4 time units per period: 250 MHz with 1 ns units
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic pwr_good, sw_beat, fab_beat, risk_major;
  logic sys_rst_n, boot_nominal;

  watchdog_boot_supervisor #(
    .SYNC_STAGES(2), .POR_CYCLES(POR), .WDT_CYCLES(WDT),
    .RST_CYCLES(RSTP), .BOOT_DELAY_CYCLES(BOOT)
  ) dut (
    .clk(clk), .pwr_good(pwr_good), .sw_beat(sw_beat), .fab_beat(fab_beat),
    .risk_major(risk_major), .sys_rst_n(sys_rst_n), .boot_nominal(boot_nominal)
  );

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic  lvl;
    int    len;
    bit    exact;
    logic  boot;
    string req;
  } seg_t;
  seg_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic lvl, input int len, input bit exact,
                      input logic boot, input string req);
    seg_t s;
    s.lvl = lvl; s.len = len; s.exact = exact; s.boot = boot; s.req = req;
    exp_q.push_back(s);
  endtask

  // monitor: measures every reset/release interval and scores it
  initial begin
    bit   tracking;
    logic cur;
    int   len;
    logic boot0;
    seg_t e;
    tracking = 1'b0;
    forever begin
      @(negedge clk);
      if (!tracking) begin
        if (sys_rst_n === 1'b1) begin
          tracking = 1'b1; cur = 1'b1; len = 1; boot0 = boot_nominal;
        end
      end else if (sys_rst_n === cur) begin
        len++;
      end else begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected reset transition, interval length", len, 0);
        end else begin
          e = exp_q.pop_front();
          check(cur === e.lvl, e.req, "interval level", int'(cur), int'(e.lvl));
          if (e.exact) check(len == e.len, e.req, "interval length", len, e.len);
          else         check(len >= e.len, e.req, "interval length (minimum)", len, e.len);
          check(boot0 === e.boot, e.req, "boot select at interval start",
                int'(boot0), int'(e.boot));
        end
        cur = sys_rst_n; len = 1; boot0 = boot_nominal;
      end
    end
  end

  // background heartbeat generator
  bit sw_tog  = 1'b0;
  bit fab_tog = 1'b0;
  initial begin
    int tick;
    tick = 0;
    forever begin
      @(negedge clk);
      tick++;
      if (sw_tog)  sw_beat  = ((tick % 40) < 4);
      if (fab_tog) fab_beat = (((tick + 25) % 40) < 4);
    end
  end

  task automatic wait_level(input logic v);
    do @(negedge clk); while (sys_rst_n !== v);
  endtask

  task automatic power_up();
    int n_rst;
    int n_boot;
    n_rst = 0; n_boot = 0;
    @(negedge clk); #1 pwr_good = 1'b1;
    for (int n = 1; n <= 400 && n_boot == 0; n++) begin
      @(negedge clk);
      if (n_rst == 0 && sys_rst_n === 1'b1) begin
        n_rst = n;
        check(boot_nominal === 1'b1, "R3", "boot select at first release",
              int'(boot_nominal), 1);
      end
      if (n_boot == 0 && boot_nominal === 1'b0) n_boot = n;
    end
    check(n_rst == int'(POR) + 2, "R2", "edges until reset release", n_rst, POR + 2);
    check(n_boot == int'(BOOT) + 2, "R4", "edges until redundant select", n_boot, BOOT + 2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // bench watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R7: bench run hung, actual=100000 cycles expected=completion");
    finish_run();
  end

  // driver / stimulus
  initial begin
    pwr_good = 1'b0; sw_beat = 1'b0; fab_beat = 1'b0; risk_major = 1'b0;
    repeat (5) @(negedge clk);
    check(sys_rst_n === 1'b0, "R1", "reset while power low", int'(sys_rst_n), 0);
    check(boot_nominal === 1'b1, "R1", "boot select while power low", int'(boot_nominal), 1);

    // silent first boot: times out, second reset selects redundant
    push(1'b1, WDT, 1'b1, 1'b1, "R5");
    power_up();
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");

    // R7: both heartbeats toggling keep the system alive
    wait_level(1'b1); push(1'b1, 1000, 1'b0, 1'b0, "R7");
    sw_tog = 1'b1; fab_tog = 1'b1;
    repeat (1000) @(negedge clk);
    sw_tog = 1'b0; fab_tog = 1'b0; sw_beat = 1'b0; fab_beat = 1'b0;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");

    // R8: one alive event completed by sw rise 30 samples after release
    wait_level(1'b1); push(1'b1, 30 + WDT + 4, 1'b1, 1'b0, "R8");
    repeat (5) @(negedge clk); fab_beat = 1'b1;
    repeat (4) @(negedge clk); fab_beat = 1'b0;
    repeat (21) @(negedge clk); sw_beat = 1'b1;
    repeat (4) @(negedge clk); sw_beat = 1'b0;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R4");
    sw_beat = 1'b1; fab_beat = 1'b1;

    // R9: inputs held high do not feed the watchdog
    wait_level(1'b1); push(1'b1, WDT, 1'b1, 1'b0, "R9");
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");
    sw_beat = 1'b0; fab_beat = 1'b0;

    // R10: software heartbeat alone
    wait_level(1'b1); push(1'b1, WDT, 1'b1, 1'b0, "R10");
    sw_tog = 1'b1;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");
    sw_tog = 1'b0; sw_beat = 1'b0;

    // R10: fabric heartbeat alone
    wait_level(1'b1); push(1'b1, WDT, 1'b1, 1'b0, "R10");
    fab_tog = 1'b1;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");
    fab_tog = 1'b0; fab_beat = 1'b0; risk_major = 1'b1;

    // R11: risk flag vetoes both heartbeats
    wait_level(1'b1); push(1'b1, WDT, 1'b1, 1'b0, "R11");
    sw_tog = 1'b1; fab_tog = 1'b1;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");
    sw_tog = 1'b0; fab_tog = 1'b0; sw_beat = 1'b0; fab_beat = 1'b0; risk_major = 1'b0;
    repeat (2) @(negedge clk); fab_beat = 1'b1;
    repeat (2) @(negedge clk); fab_beat = 1'b0;

    // R12: fabric edge inside reset must not pair with later sw edge
    wait_level(1'b1); push(1'b1, WDT, 1'b1, 1'b0, "R12");
    repeat (30) @(negedge clk); sw_beat = 1'b1;
    repeat (4) @(negedge clk); sw_beat = 1'b0;
    wait_level(1'b0); push(1'b0, RSTP, 1'b1, 1'b0, "R6");

    // R13: power drop mid-run
    wait_level(1'b1); push(1'b1, 50, 1'b0, 1'b0, "R13");
    push(1'b0, 1, 1'b0, 1'b1, "R13");
    repeat (50) @(negedge clk);
    #1 pwr_good = 1'b0;
    #0.5;
    check(sys_rst_n === 1'b0, "R13", "reset right after power drop", int'(sys_rst_n), 0);
    check(boot_nominal === 1'b1, "R13", "boot select right after power drop",
          int'(boot_nominal), 1);
    @(negedge clk);
    check(sys_rst_n === 1'b0, "R13", "reset one sample after power drop", int'(sys_rst_n), 0);
    check(boot_nominal === 1'b1, "R13", "boot select one sample after power drop",
          int'(boot_nominal), 1);
    repeat (5) @(negedge clk);

    // second power-up: nominal again, same delays
    power_up();
    check(exp_q.size() == 0, "R2", "unscored intervals left", exp_q.size(), 0);
    finish_run();
  end
endmodule